// File: doc/BRIEF.md
# Conversion Request Slot Arbiter

This block decides which of several request sources may start the next conversion on a shared converter. Each source raises a request line. A per-source generation gate lets the request be captured, and the arbiter holds it as pending. A slot scanner visits one slot per source and spends a fixed number of clock cycles in each slot. At the end of every full round, the arbiter picks the pending source with the highest priority among those whose slot is enabled. It then issues a one-cycle start pulse together with that source's ID.

There are two scan modes. In on-demand mode the scanner rests at the beginning of a round while nothing is pending, so a request on an idle converter is always started after the same number of cycles. In free-running mode the scanner never rests, so the latency depends on the phase of the scan. A pending request on a slot that is switched off is never started. It still counts as pending, though, so it keeps the scanner moving, and that makes the latency of the other sources vary. A request with strictly higher priority can displace a conversion that is already running. In that case the arbiter raises cancel together with the new start, and the displaced source goes back to pending.

All pins are plain control and status signals. The block accepts no back-pressure on its outputs. The converter holds back further starts only through its busy signal.

Top module: `cra_slot_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `start_o` and `cancel_o` are 0 and `src_id_o` is 0.
- R2: A request on source i is captured as pending only if `gate_en_i[i]` is 1 when it is sampled. While `gate_en_i[i]` is 0, any pending request of source i is cleared. A request that arrives with the gate at 0 never leads to a start.
- R3: With `on_demand_i` at 1 and no source pending, the scanner rests at the first cycle of slot 0, so a later request sees the same latency as one made on a freshly reset block.
- R4: In on-demand mode, with the converter idle and the scanner resting, a request sampled at clock edge n gives `start_o` high in the cycle after edge n + NUM_SRC*SLOT_CYCLES. With the defaults this is 8 edges later.
- R5: A source whose `slot_en_i` bit is 0 is never started, but its pending request keeps the scanner running. With the defaults, if a disabled source 1 request is sampled at edge n and a source 0 request at edge n+3, source 0 starts after edge n+8.
- R6: At the end of a round the winner is the eligible pending source with the highest value in its `prio_i` field. Source i's field is bits [i*PRIO_W +: PRIO_W]. On equal priority the lower index wins.
- R7: `start_o` is high for exactly one cycle. `src_id_o` changes only in a cycle in which `start_o` is high, and it otherwise holds the last started source.
- R8: A start without cancel is issued only if, at the deciding edge, `conv_busy_i` was 0 and the previous conversion had finished. A conversion counts as finished once busy has been seen high and has then dropped.
- R9: If a running conversion was started for priority p and the round winner has a priority strictly above p, the arbiter pulses `cancel_o` and `start_o` in the same cycle, with `src_id_o` set to the new winner.
- R10: A source displaced by R9 becomes pending again, and it is started once the displacing conversion has finished.
- R11: With `on_demand_i` at 0 the scanner advances every cycle whatever is pending. With the defaults, a request sampled 1 edge after a round-end edge starts after 7 more edges, and one sampled 4 edges after it starts after 4 more edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_demand_i | input | 1 | 1: the scanner rests when nothing is pending; 0: the scanner runs freely |
| slot_en_i | input | NUM_SRC | Per-source enable for taking part in arbitration |
| gate_en_i | input | NUM_SRC | Per-source request-generation gate |
| req_i | input | NUM_SRC | Per-source request, sampled every clock |
| prio_i | input | NUM_SRC*PRIO_W | Per-source priority, packed by source index |
| conv_busy_i | input | 1 | Converter is busy with a conversion |
| start_o | output | 1 | One-cycle pulse that starts a conversion |
| cancel_o | output | 1 | Pulses with start_o when the running conversion is displaced |
| src_id_o | output | ID_W | Source of the most recent start |

## Verification
On every cycle the assertions check the following: the start pulse is one cycle wide, the source ID holds between starts, cancel never appears without a start, no start names a disabled slot, and a plain start never follows a busy converter. The bench's scenarios are the only place that shows the timing relations. These are the fixed on-demand latency, the shortened latency when a disabled slot keeps the scanner running, and the phase-dependent latency in free-running mode. The scenarios also show the priority order with its tie rule, the effect of the gate, and the re-arming and later restart of a displaced source.

// File: rtl/cra_pkg.sv
package cra_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cra_slot_scan.sv
module cra_slot_scan
  import cra_pkg::*;
#(
  parameter int NUM_SRC     = 2,
  parameter int SLOT_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_demand_i,
  input  logic any_pend_i,
  output logic round_end_o
);
  localparam int CYC_W  = idx_width(SLOT_CYCLES);
  localparam int SLOT_W = idx_width(NUM_SRC);
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_CYCLES - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SRC - 1);

  scan_state_e       state;
  logic [CYC_W-1:0]  cyc_q;
  logic [SLOT_W-1:0] slot_q;
  logic              cyc_last, slot_last;

  // On-demand with nothing pending: rest at the round origin
  assign state     = (on_demand_i && !any_pend_i) ? SCAN_IDLE : SCAN_RUN;
  assign cyc_last  = (cyc_q == CYC_LAST);
  assign slot_last = (slot_q == SLOT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (state == SCAN_IDLE) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (cyc_last) begin
      cyc_q  <= '0;
      slot_q <= slot_last ? '0 : slot_q + 1'b1;
    end else begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  assign round_end_o = (state == SCAN_RUN) && cyc_last && slot_last;

endmodule

// File: rtl/cra_pend.sv
module cra_pend #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] gate_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] rearm_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= gate_i[g] & ((flag_q & ~clr_i[g]) | req_i[g] | rearm_i[g]);
    end
    assign pend_o[g] = flag_q;
  end
endmodule

// File: rtl/cra_pick.sv
module cra_pick
  import cra_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int PRIO_W  = 2,
  localparam int ID_W   = idx_width(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        cand_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      valid_o,
  output logic [ID_W-1:0]           id_o,
  output logic [PRIO_W-1:0]         prio_o
);
  // Walk from the top index down; ">=" lets the lower index win ties
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] >= prio_o)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/cra_slot_arbiter.sv
module cra_slot_arbiter
  import cra_pkg::*;
#(
  parameter int NUM_SRC     = 2,
  parameter int SLOT_CYCLES = 4,
  parameter int PRIO_W      = 2,
  localparam int ID_W       = idx_width(NUM_SRC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      on_demand_i,
  input  logic [NUM_SRC-1:0]        slot_en_i,
  input  logic [NUM_SRC-1:0]        gate_en_i,
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic                      conv_busy_i,
  output logic                      start_o,
  output logic                      cancel_o,
  output logic [ID_W-1:0]           src_id_o
);
  logic [NUM_SRC-1:0] pend, cand, clr, rearm;
  logic               round_end, win_valid, go, preempt, conv_free;
  logic [ID_W-1:0]    win_id, id_q;
  logic [PRIO_W-1:0]  win_prio, act_prio_q;
  logic               start_q, cancel_q, active_q, busy_seen_q;

  cra_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i, .rst_ni, .req_i, .gate_i(gate_en_i),
    .clr_i(clr), .rearm_i(rearm), .pend_o(pend)
  );

  // Any pending source, enabled slot or not, keeps the scan alive
  cra_slot_scan #(.NUM_SRC(NUM_SRC), .SLOT_CYCLES(SLOT_CYCLES)) u_scan (
    .clk_i, .rst_ni, .on_demand_i, .any_pend_i(|pend), .round_end_o(round_end)
  );

  assign cand = pend & slot_en_i;

  cra_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
    .cand_i(cand), .prio_i, .valid_o(win_valid), .id_o(win_id), .prio_o(win_prio)
  );

  assign conv_free = !active_q && !conv_busy_i;
  assign preempt   = active_q && (win_prio > act_prio_q);
  assign go        = round_end && win_valid && (conv_free || preempt);

  always_comb begin
    clr   = '0;
    rearm = '0;
    if (go)            clr[win_id] = 1'b1;
    if (go && preempt) rearm[id_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q     <= 1'b0;
      cancel_q    <= 1'b0;
      id_q        <= '0;
      act_prio_q  <= '0;
      active_q    <= 1'b0;
      busy_seen_q <= 1'b0;
    end else begin
      start_q  <= go;
      cancel_q <= go && preempt;
      if (go) begin
        id_q        <= win_id;
        act_prio_q  <= win_prio;
        active_q    <= 1'b1;
        busy_seen_q <= 1'b0;
      end else if (active_q) begin
        if (conv_busy_i)      busy_seen_q <= 1'b1;
        else if (busy_seen_q) active_q    <= 1'b0;
      end
    end
  end

  assign start_o  = start_q;
  assign cancel_o = cancel_q;
  assign src_id_o = id_q;

endmodule

// File: rtl/cra_slot_arbiter_chk.sv
module cra_slot_arbiter_chk #(
  parameter int NUM_SRC = 2,
  parameter int ID_W    = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] slot_en_i,
  input logic               conv_busy_i,
  input logic               start_o,
  input logic               cancel_o,
  input logic [ID_W-1:0]    src_id_o
);
  logic [NUM_SRC-1:0] slot_en_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_en_d <= '0;
    else         slot_en_d <= slot_en_i;
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R7

  AST_ID_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> $stable(src_id_o)); // R7

  AST_CANCEL_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> start_o); // R9

  AST_SLOT_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> slot_en_d[src_id_o]); // R5

  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !cancel_o) |-> $past(!conv_busy_i)); // R8
endmodule

bind cra_slot_arbiter cra_slot_arbiter_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .slot_en_i(slot_en_i), .conv_busy_i(conv_busy_i),
  .start_o(start_o), .cancel_o(cancel_o), .src_id_o(src_id_o)
);

// File: tb/tb_cra_slot_arbiter.sv
`timescale 1ns/1ps
module tb_cra_slot_arbiter;
  localparam int HALF = 4; // 125 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       on_demand = 1'b1;
  logic [1:0] slot_en = 2'b11;
  logic [1:0] gate_en = 2'b11;
  logic [1:0] req = 2'b00;
  logic [3:0] prio = 4'h0;
  logic       conv_busy;
  logic       start, cancel;
  logic [0:0] src_id;

  int tests = 0;
  int fails = 0;
  int conv_len = 12;
  int conv_cnt;
  int n_start0 = 0, n_start1 = 0, n_cancel = 0, id_glitch = 0;
  logic [0:0] prev_id = '0;

  always #HALF clk = ~clk;

  cra_slot_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .on_demand_i(on_demand), .slot_en_i(slot_en),
    .gate_en_i(gate_en), .req_i(req), .prio_i(prio), .conv_busy_i(conv_busy),
    .start_o(start), .cancel_o(cancel), .src_id_o(src_id)
  );

  // Converter model: busy for conv_len cycles after each start, restarted by a new start
  always @(posedge clk) begin
    if (!rst_n)        conv_cnt <= 0;
    else if (start)    conv_cnt <= conv_len;
    else if (conv_cnt > 0) conv_cnt <= conv_cnt - 1;
  end
  assign conv_busy = (conv_cnt != 0);

  always @(negedge clk) begin
    if (rst_n) begin
      if (start && src_id == 1'b0) n_start0++;
      if (start && src_id == 1'b1) n_start1++;
      if (cancel) n_cancel++;
      if (!start && src_id != prev_id) id_glitch++;
    end
    prev_id = src_id;
  end

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Starts counting at the next negedge; k=1 is the cycle after the sampling edge
  task automatic measure(input int limit, output int lat, output int id, output int canc);
    lat = -1; id = -1; canc = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (k == 1) req = 2'b00;
      if (start) begin
        lat = k; id = int'(src_id); canc = int'(cancel);
        break;
      end
    end
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; on_demand = 1'b1; slot_en = 2'b11; gate_en = 2'b11;
    req = 2'b00; prio = 4'h0; conv_len = 12;
    idle_wait(3);
    check(start == 1'b0 && cancel == 1'b0, "R1", "start/cancel in reset", int'({start, cancel}), 0);
    check(src_id == 1'b0, "R1", "src_id in reset", int'(src_id), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(start == 1'b0 && src_id == 1'b0, "R1", "outputs after reset", int'({start, src_id}), 0);
  endtask

  task automatic t_latency();
    int lat, id, c;
    req = 2'b01;
    measure(30, lat, id, c);
    check(lat == 9, "R4", "source0 latency", lat, 9);
    check(id == 0, "R4", "source0 id", id, 0);
    @(negedge clk);
    check(start == 1'b0, "R7", "start width", int'(start), 0);
    idle_wait(30);
    req = 2'b10;
    measure(30, lat, id, c);
    check(lat == 9 && id == 1, "R3", "latency after rest", lat, 9);
    idle_wait(30);
  endtask

  task automatic t_priority();
    int lat, id, c;
    prio = {2'd2, 2'd1};
    req = 2'b11;
    measure(30, lat, id, c);
    check(id == 1, "R6", "higher priority wins", id, 1);
    measure(80, lat, id, c);
    check(id == 0, "R6", "second winner", id, 0);
    check(lat > conv_len, "R8", "waited for busy", lat, conv_len + 1);
    idle_wait(30);
    prio = {2'd1, 2'd1};
    req = 2'b11;
    measure(30, lat, id, c);
    check(id == 0, "R6", "tie goes to source0", id, 0);
    measure(80, lat, id, c);
    check(id == 1, "R6", "tie loser follows", id, 1);
    idle_wait(30);
    prio = 4'h0;
  endtask

  task automatic t_gate();
    int lat, id, c;
    gate_en = 2'b01;
    req = 2'b10;
    measure(30, lat, id, c);
    check(lat == -1, "R2", "gated request ignored", lat, -1);
    gate_en = 2'b11;
    req = 2'b10;
    @(negedge clk); req = 2'b00;
    @(negedge clk);
    gate_en = 2'b01;
    measure(30, lat, id, c);
    check(lat == -1, "R2", "gate clears pending", lat, -1);
    gate_en = 2'b11;
    idle_wait(3);
    req = 2'b01;
    measure(30, lat, id, c);
    check(lat == 9, "R3", "rest after gate clear", lat, 9);
    idle_wait(30);
  endtask

  task automatic t_slot_disabled();
    int lat, id, c, snap;
    slot_en = 2'b01;
    req = 2'b10;
    @(negedge clk); req = 2'b00;
    @(negedge clk);
    @(negedge clk);
    req = 2'b01;
    measure(30, lat, id, c);
    check(lat == 6, "R5", "latency shortened by disabled slot", lat, 6);
    check(id == 0, "R5", "enabled source started", id, 0);
    snap = n_start1;
    idle_wait(60);
    check(n_start1 == snap, "R5", "disabled slot never started", n_start1, snap);
    gate_en = 2'b01;
    idle_wait(2);
    gate_en = 2'b11;
    slot_en = 2'b11;
    idle_wait(5);
    req = 2'b01;
    measure(30, lat, id, c);
    check(lat == 9, "R2", "fixed latency after gating off", lat, 9);
    idle_wait(30);
  endtask

  task automatic t_preempt();
    int lat, id, c, snap;
    conv_len = 60;
    prio = {2'd3, 2'd0};
    req = 2'b01;
    measure(30, lat, id, c);
    check(id == 0 && c == 0, "R9", "low priority start", id, 0);
    idle_wait(3);
    snap = n_cancel;
    req = 2'b10;
    measure(20, lat, id, c);
    check(id == 1, "R9", "preempting id", id, 1);
    check(c == 1, "R9", "cancel with start", c, 1);
    measure(150, lat, id, c);
    check(id == 0 && c == 0, "R10", "displaced source restarted", id, 0);
    check(lat > 60, "R10", "restart after displacing conversion", lat, 61);
    check(n_cancel == snap + 1, "R9", "single cancel", n_cancel, snap + 1);
    idle_wait(70);
    conv_len = 12;
    prio = 4'h0;
  endtask

  task automatic t_freerun();
    int lat, id, c;
    on_demand = 1'b0;
    conv_len = 2;
    idle_wait(21);
    req = 2'b01;
    measure(20, lat, id, c);
    check(lat >= 1 && lat <= 9, "R11", "free-run latency range", lat, 9);
    req = 2'b01;
    measure(20, lat, id, c);
    check(lat == 8, "R11", "phase 1 latency", lat, 8);
    idle_wait(3);
    req = 2'b01;
    measure(20, lat, id, c);
    check(lat == 5, "R11", "phase 4 latency", lat, 5);
    on_demand = 1'b1;
    conv_len = 12;
    idle_wait(20);
  endtask

  initial begin
    #(200000 * 2 * HALF);
    fails++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_priority();
    t_gate();
    t_slot_disabled();
    t_preempt();
    t_freerun();
    check(id_glitch == 0, "R7", "src_id changed without start", id_glitch, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule